// File: doc/BRIEF.md
# Completion Ring Writer with Phase Bit

This block records finished requests in memory. Each completion queue owns a circular buffer whose size is a power of two. For every finished request the block writes an 8-byte record at the ring's current slot. The first write carries a 32-bit status word. The second write carries a 32-bit completion word, which holds the request id, a scheduler-error flag and a phase (generation) bit. The phase bit starts at 1 when a ring is configured and inverts each time the ring's slot index returns to zero. Software therefore detects fresh records by comparing the phase bit, and no head pointer has to be exchanged.

Software programs a trigger position for each ring. This is the slot index with the phase bit placed directly above the index bits, typically one past the last slot it has consumed. When the block writes the record that matches this position, it sets the queue's interrupt status bit, provided the queue's enable bit is on. A single interrupt line is the OR of the enabled status bits. Writing a mask clears status bits. Memory is driven through a plain address/data/valid write port that always accepts.

Top module: `cq_ring_writer`

## Requirements
- R1: After synchronous reset, `cmp_ready` is 1, `mem_valid` is 0, `irq_status` is all zero, `irq` is 0, and every ring is disabled.
- R2: In the cycle after a completion is accepted on an enabled ring, `mem_valid` is 1, `mem_addr` is ring base + 8 × slot index, and `mem_data` is the status word.
- R3: In the next cycle, `mem_valid` is 1 and `mem_addr` is the previous address + 4. `mem_data` is the completion word: request id in bits 31:16, zero in bits 15:2, the error flag in bit 1, and the phase bit in bit 0. The status word is always written before the completion word.
- R4: The slot index advances by one per record. It wraps to 0 after 2^(code−3) records, where code is the size code. The phase bit is 1 after configuration and inverts on every wrap.
- R5: A size code of 7 to 14 enables the ring with 16 to 2048 slots. Any other code, 0 included, disables it. A completion sent to a disabled ring is accepted, produces no memory write and leaves `cmp_ready` at 1. Configuring a ring resets its index to 0 and its phase to 1.
- R6: The low three bits of the programmed base are ignored, so every record address is 8-byte aligned.
- R7: A queue's status bit sets one cycle after its completion word is presented, only if {phase, index} of that record equals the trigger position and the enable bit is 1. The phase bit sits at bit (code−3) and the comparison covers bits (code−3):0.
- R8: `irq` is 1 exactly when some status bit and its enable bit are both 1. Clearing an enable bit drops `irq` but leaves the status bit unchanged.
- R9: A clear write removes the status bits named in its mask. If a set and a clear hit the same bit in the same cycle, the set wins.
- R10: `cmp_ready` is 0 during both memory-write cycles of a record, so at most one record is accepted every three cycles.
- R11: Each queue keeps its own base, size, index, phase and trigger. Traffic on one queue does not move another queue's slot position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configure ring `cfg_qid` |
| cfg_qid | input | $clog2(NQ) | Queue being configured |
| cfg_base | input | AW | Ring base byte address (low 3 bits ignored) |
| cfg_size_code | input | 4 | log2 of ring bytes; 7..14 enable, others disable |
| trig_we | input | 1 | Write trigger position of `trig_qid` |
| trig_qid | input | $clog2(NQ) | Queue whose trigger is written |
| trig_pos | input | 12 | {phase, index} trigger position |
| cmp_valid | input | 1 | Completion offered |
| cmp_ready | output | 1 | Completion can be accepted |
| cmp_qid | input | $clog2(NQ) | Target completion queue |
| cmp_rid | input | 16 | Request id |
| cmp_status | input | 32 | Status word |
| cmp_err | input | 1 | Scheduler error flag |
| mem_valid | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write byte address |
| mem_data | output | 32 | Memory write data |
| irq_en | input | NQ | Interrupt enable per queue |
| irq_clr_we | input | 1 | Apply clear mask this cycle |
| irq_clr_mask | input | NQ | Status bits to clear |
| irq_status | output | NQ | Per-queue interrupt status |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted slot index shows up on the very next record as a wrong `mem_addr`, two cycles after acceptance at the latest. A phase bit that fails to flip appears in bit 0 of the completion word on the first record after the wrap, so the bench sends one record past a full ring. A wrong trigger comparison or a wrong phase position shows up in `irq_status` one cycle after the completion word. The bench therefore checks both a phase-mismatched trigger that must stay silent and a matching one that must fire. Set/clear priority and enable gating are checked at the exact cycle where they collide.

// File: rtl/cqw_pkg.sv
// Shared constants, types and helpers for the completion ring writer.
package cqw_pkg;
    localparam int CODE_W   = 4;
    localparam int MIN_CODE = 7;
    localparam int MAX_CODE = 14;
    localparam int IDX_W    = MAX_CODE - 3;   // slot index bits for the largest ring
    localparam int TRIG_W   = IDX_W + 1;      // index plus phase bit
    localparam int RID_W    = 16;
    localparam int WORD_W   = 32;

    typedef enum logic [1:0] {W_IDLE, W_STAT, W_COMP} wr_state_t;

    // True when a size code selects a usable ring.
    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        return (c >= CODE_W'(MIN_CODE)) && (c <= CODE_W'(MAX_CODE));
    endfunction

    // Highest slot index of a ring of the given code (2^(code-3) - 1).
    function automatic logic [IDX_W-1:0] last_idx(input logic [CODE_W-1:0] c);
        return {IDX_W{1'b1}} >> (CODE_W'(MAX_CODE) - c);
    endfunction
endpackage

// File: rtl/cqw_ring_state.sv
// Per-queue ring bookkeeping: base, size code, slot index, phase bit and
// trigger position. Presents the state of queue rd_qid combinationally,
// including the record address and whether the current slot matches the
// trigger. Assumes NQ is a power of two so rd_qid never indexes out of range.
module cqw_ring_state
    import cqw_pkg::*;
#(
    parameter int NQ = 4,
    parameter int AW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [$clog2(NQ)-1:0] cfg_qid,
    input  logic [AW-1:0]         cfg_base,
    input  logic [CODE_W-1:0]     cfg_code,
    input  logic                  trig_we,
    input  logic [$clog2(NQ)-1:0] trig_qid,
    input  logic [TRIG_W-1:0]     trig_pos,
    input  logic                  adv,
    input  logic [$clog2(NQ)-1:0] rd_qid,
    output logic                  rd_on,
    output logic [AW-1:0]         rd_addr,
    output logic                  rd_gen,
    output logic                  rd_hit
);
    localparam int QW = $clog2(NQ);

    logic [AW-4:0]       base_q [NQ];
    logic [CODE_W-1:0]   code_q [NQ];
    logic [IDX_W-1:0]    idx_q  [NQ];
    logic                gen_q  [NQ];
    logic [TRIG_W-1:0]   trig_q [NQ];

    // Configuration and slot advance; a configure beats a same-cycle advance.
    always_ff @(posedge clk) begin
        for (int q = 0; q < NQ; q++) begin
            if (!rst_n) begin
                base_q[q] <= '0;
                code_q[q] <= '0;
                idx_q[q]  <= '0;
                gen_q[q]  <= 1'b1;
            end else if (cfg_we && cfg_qid == QW'(q)) begin
                base_q[q] <= cfg_base[AW-1:3];
                code_q[q] <= code_legal(cfg_code) ? cfg_code : '0;
                idx_q[q]  <= '0;
                gen_q[q]  <= 1'b1;
            end else if (adv && rd_qid == QW'(q)) begin
                if (idx_q[q] == last_idx(code_q[q])) begin
                    idx_q[q] <= '0;
                    gen_q[q] <= ~gen_q[q];
                end else begin
                    idx_q[q] <= idx_q[q] + 1'b1;
                end
            end
        end
    end

    // Trigger positions written by software.
    always_ff @(posedge clk) begin
        for (int q = 0; q < NQ; q++) begin
            if (!rst_n)
                trig_q[q] <= '0;
            else if (trig_we && trig_qid == QW'(q))
                trig_q[q] <= trig_pos;
        end
    end

    logic [CODE_W-1:0] sel_code;
    logic [IDX_W-1:0]  sel_idx;
    logic [TRIG_W-1:0] sel_pos;
    logic [TRIG_W-1:0] sel_mask;

    // Read view of the selected queue and its trigger comparison.
    always_comb begin
        sel_code = code_q[rd_qid];
        sel_idx  = idx_q[rd_qid];
        rd_on    = (sel_code != '0);
        rd_gen   = gen_q[rd_qid];
        rd_addr  = {base_q[rd_qid], 3'b000} + AW'({sel_idx, 3'b000});
        sel_pos  = TRIG_W'(sel_idx) | (TRIG_W'(rd_gen) << (sel_code - CODE_W'(3)));
        sel_mask = {last_idx(sel_code), 1'b1};
        rd_hit   = ((sel_pos ^ trig_q[rd_qid]) & sel_mask) == '0;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_chk
        // R4: a wrap returns the index to zero and inverts the phase.
        assert_wrap_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && rd_qid == QW'(q) && !(cfg_we && cfg_qid == QW'(q)) &&
             idx_q[q] == last_idx(code_q[q]))
            |=> (idx_q[q] == '0 && gen_q[q] != $past(gen_q[q])));
        // R5: configuring a ring restarts it at slot 0 with phase 1.
        assert_cfg_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_qid == QW'(q)) |=> (idx_q[q] == '0 && gen_q[q]));
    end
endmodule

// File: rtl/cqw_writer.sv
// Record writer: accepts one completion, emits the status word and then the
// completion word on the memory port in two consecutive cycles. Completions
// for disabled rings are accepted and dropped. The memory port never stalls.
module cqw_writer
    import cqw_pkg::*;
#(
    parameter int NQ = 4,
    parameter int AW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmp_valid,
    output logic                  cmp_ready,
    input  logic [$clog2(NQ)-1:0] cmp_qid,
    input  logic [RID_W-1:0]      cmp_rid,
    input  logic [WORD_W-1:0]     cmp_status,
    input  logic                  cmp_err,
    input  logic                  rd_on,
    input  logic [AW-1:0]         rd_addr,
    input  logic                  rd_gen,
    input  logic                  rd_hit,
    output logic                  adv,
    output logic                  mem_valid,
    output logic [AW-1:0]         mem_addr,
    output logic [WORD_W-1:0]     mem_data,
    output logic                  done,
    output logic [$clog2(NQ)-1:0] done_qid,
    output logic                  done_hit
);
    wr_state_t         st;
    logic [AW-1:0]     addr_r;
    logic [WORD_W-1:0] stat_r;
    logic [WORD_W-1:0] cword_r;

    assign cmp_ready = (st == W_IDLE);
    assign adv       = cmp_valid && cmp_ready && rd_on;

    // Sequencer: idle -> status word -> completion word -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= W_IDLE;
        end else begin
            unique case (st)
                W_IDLE:  if (adv) st <= W_STAT;
                W_STAT:  st <= W_COMP;
                default: st <= W_IDLE;
            endcase
        end
    end

    // Capture of the record contents at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_r   <= '0;
            stat_r   <= '0;
            cword_r  <= '0;
            done_qid <= '0;
            done_hit <= 1'b0;
        end else if (adv) begin
            addr_r   <= rd_addr;
            stat_r   <= cmp_status;
            cword_r  <= {cmp_rid, 14'b0, cmp_err, rd_gen};
            done_qid <= cmp_qid;
            done_hit <= rd_hit;
        end
    end

    // Memory port view of the current phase.
    always_comb begin
        mem_valid = (st != W_IDLE);
        mem_addr  = (st == W_COMP) ? addr_r + AW'(4) : addr_r;
        mem_data  = (st == W_COMP) ? cword_r : stat_r;
        done      = (st == W_COMP);
    end

    // R3: the completion word follows the status word at the next address.
    assert_stat_then_comp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_STAT) |=> (mem_valid && mem_addr == $past(mem_addr) + AW'(4)));
    // R10: no acceptance while a record is being written.
    assert_ready_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !cmp_ready);
    // R6: status words land on 8-byte boundaries.
    assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && st == W_STAT) |-> mem_addr[2:0] == 3'b000);
endmodule

// File: rtl/cqw_irq.sv
// Interrupt status per queue: set by a matching record on an enabled queue,
// cleared by a software mask, set winning over clear. Drives the combined line.
module cqw_irq #(
    parameter int NQ = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_valid,
    input  logic [$clog2(NQ)-1:0] set_qid,
    input  logic [NQ-1:0]         irq_en,
    input  logic                  clr_we,
    input  logic [NQ-1:0]         clr_mask,
    output logic [NQ-1:0]         irq_status,
    output logic                  irq
);
    logic [NQ-1:0] set_vec;
    logic [NQ-1:0] clr_vec;

    assign set_vec = set_valid ? ((NQ'(1) << set_qid) & irq_en) : '0;
    assign clr_vec = clr_we ? clr_mask : '0;
    assign irq     = |(irq_status & irq_en);

    // Status update with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_status <= '0;
        else
            irq_status <= (irq_status & ~clr_vec) | set_vec;
    end

    // R9: an enabled set lands even when a clear hits the same bit.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && irq_en[set_qid]) |=> irq_status[$past(set_qid)]);
    // R9: cleared bits without a competing set are gone next cycle.
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && (clr_mask & ~set_vec) != '0)
        |=> ((irq_status & $past(clr_mask & ~set_vec)) == '0));

    for (genvar i = 0; i < NQ; i++) begin : g_chk
        // R7: a status bit only rises for an enabled queue.
        assert_rise_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_status[i]) |-> $past(irq_en[i]));
    end
endmodule

// File: rtl/cq_ring_writer.sv
// Completion ring writer top: ring state, record writer and interrupt status.
// Assumes the memory write port accepts every cycle and NQ is a power of two.
module cq_ring_writer
    import cqw_pkg::*;
#(
    parameter int NQ = 4,
    parameter int AW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [$clog2(NQ)-1:0] cfg_qid,
    input  logic [AW-1:0]         cfg_base,
    input  logic [CODE_W-1:0]     cfg_size_code,
    input  logic                  trig_we,
    input  logic [$clog2(NQ)-1:0] trig_qid,
    input  logic [TRIG_W-1:0]     trig_pos,
    input  logic                  cmp_valid,
    output logic                  cmp_ready,
    input  logic [$clog2(NQ)-1:0] cmp_qid,
    input  logic [RID_W-1:0]      cmp_rid,
    input  logic [WORD_W-1:0]     cmp_status,
    input  logic                  cmp_err,
    output logic                  mem_valid,
    output logic [AW-1:0]         mem_addr,
    output logic [WORD_W-1:0]     mem_data,
    input  logic [NQ-1:0]         irq_en,
    input  logic                  irq_clr_we,
    input  logic [NQ-1:0]         irq_clr_mask,
    output logic [NQ-1:0]         irq_status,
    output logic                  irq
);
    logic                  rd_on, rd_gen, rd_hit, adv;
    logic [AW-1:0]         rd_addr;
    logic                  done, done_hit;
    logic [$clog2(NQ)-1:0] done_qid;

    cqw_ring_state #(.NQ(NQ), .AW(AW)) u_state (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_base(cfg_base), .cfg_code(cfg_size_code),
        .trig_we(trig_we), .trig_qid(trig_qid), .trig_pos(trig_pos),
        .adv(adv), .rd_qid(cmp_qid),
        .rd_on(rd_on), .rd_addr(rd_addr), .rd_gen(rd_gen), .rd_hit(rd_hit)
    );

    cqw_writer #(.NQ(NQ), .AW(AW)) u_writer (
        .clk(clk), .rst_n(rst_n),
        .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_qid(cmp_qid),
        .cmp_rid(cmp_rid), .cmp_status(cmp_status), .cmp_err(cmp_err),
        .rd_on(rd_on), .rd_addr(rd_addr), .rd_gen(rd_gen), .rd_hit(rd_hit),
        .adv(adv),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .done(done), .done_qid(done_qid), .done_hit(done_hit)
    );

    cqw_irq #(.NQ(NQ)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_valid(done && done_hit), .set_qid(done_qid),
        .irq_en(irq_en), .clr_we(irq_clr_we), .clr_mask(irq_clr_mask),
        .irq_status(irq_status), .irq(irq)
    );
endmodule

// File: tb/cq_ring_writer_test.sv
module cq_ring_writer_test;
    localparam int NQ = 4;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_qid;
    logic [31:0] cfg_base;
    logic [3:0]  cfg_size_code;
    logic        trig_we;
    logic [1:0]  trig_qid;
    logic [11:0] trig_pos;
    logic        cmp_valid;
    logic        cmp_ready;
    logic [1:0]  cmp_qid;
    logic [15:0] cmp_rid;
    logic [31:0] cmp_status;
    logic        cmp_err;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  irq_en;
    logic        irq_clr_we;
    logic [3:0]  irq_clr_mask;
    logic [3:0]  irq_status;
    logic        irq;

    int checks = 0;
    int failures = 0;

    // Reference model of each ring
    logic [31:0] m_base [NQ];
    int          m_code [NQ];
    int          m_idx  [NQ];
    logic        m_gen  [NQ];

    always #2 clk = ~clk;

    cq_ring_writer #(.NQ(NQ), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_base(cfg_base), .cfg_size_code(cfg_size_code),
        .trig_we(trig_we), .trig_qid(trig_qid), .trig_pos(trig_pos),
        .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_qid(cmp_qid),
        .cmp_rid(cmp_rid), .cmp_status(cmp_status), .cmp_err(cmp_err),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .irq_en(irq_en), .irq_clr_we(irq_clr_we), .irq_clr_mask(irq_clr_mask),
        .irq_status(irq_status), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int q, input logic [31:0] base, input int code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_qid = 2'(q); cfg_base = base; cfg_size_code = 4'(code);
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[q] = base & ~32'h7;
        m_code[q] = (code >= 7 && code <= 14) ? code : 0;
        m_idx[q]  = 0;
        m_gen[q]  = 1'b1;
    endtask

    task automatic set_trig(input int q, input logic [11:0] pos);
        @(negedge clk);
        trig_we = 1'b1; trig_qid = 2'(q); trig_pos = pos;
        @(negedge clk);
        trig_we = 1'b0;
    endtask

    // One completion; checks both memory words and the ready gap, and returns
    // one cycle after the completion word so irq_status is already updated.
    task automatic push(input int q, input logic [15:0] rid, input logic [31:0] st,
                        input logic err, input bit clr_mid);
        logic [31:0] ea;
        @(negedge clk);
        chk("R10", "ready before offer", cmp_ready, 1'b1);
        cmp_valid = 1'b1; cmp_qid = 2'(q); cmp_rid = rid; cmp_status = st; cmp_err = err;
        @(negedge clk);
        cmp_valid = 1'b0;
        if (m_code[q] == 0) begin
            chk("R5", "no write for disabled ring", mem_valid, 1'b0);
            chk("R5", "ready stays high", cmp_ready, 1'b1);
            @(negedge clk);
            chk("R5", "still no write", mem_valid, 1'b0);
        end else begin
            ea = m_base[q] + 32'(m_idx[q] * 8);
            chk("R2", "status valid", mem_valid, 1'b1);
            chk("R2", "status addr", mem_addr, ea);
            chk("R2", "status data", mem_data, st);
            chk("R10", "ready low in status", cmp_ready, 1'b0);
            @(negedge clk);
            chk("R3", "compl valid", mem_valid, 1'b1);
            chk("R3", "compl addr", mem_addr, ea + 32'd4);
            chk("R3", "compl data", mem_data, {rid, 14'b0, err, m_gen[q]});
            chk("R10", "ready low in compl", cmp_ready, 1'b0);
            if (clr_mid) begin
                irq_clr_we = 1'b1; irq_clr_mask = 4'(1 << q);
            end
            @(negedge clk);
            irq_clr_we = 1'b0;
            chk("R10", "ready back", cmp_ready, 1'b1);
            chk("R3", "write ends", mem_valid, 1'b0);
            m_idx[q]++;
            if (m_idx[q] == (1 << (m_code[q] - 3))) begin
                m_idx[q] = 0;
                m_gen[q] = ~m_gen[q];
            end
        end
    endtask

    task automatic t_reset();
        chk("R1", "ready", cmp_ready, 1'b1);
        chk("R1", "mem_valid", mem_valid, 1'b0);
        chk("R1", "irq_status", irq_status, 4'b0);
        chk("R1", "irq", irq, 1'b0);
    endtask

    task automatic t_wrap();
        cfg(0, 32'h1000, 7);                      // 16 slots
        for (int i = 0; i < 17; i++)
            push(0, 16'(16'h100 + i), 32'(32'hA000 + i), 1'(i & 1), 1'b0);
        chk("R4", "wrapped index", 32'(m_idx[0]), 32'd1);
        chk("R4", "phase after wrap", m_gen[0], 1'b0);
        chk("R7", "no status with enable off", irq_status, 4'b0);
    endtask

    task automatic t_align();
        cfg(1, 32'h2005, 8);                      // R6: base low bits dropped
        push(1, 16'h0011, 32'h5555_0001, 1'b0, 1'b0);
        chk("R6", "next addr aligned", m_base[1], 32'h2000);
    endtask

    task automatic t_disabled();
        cfg(2, 32'h3000, 0);
        push(2, 16'h0022, 32'h1, 1'b0, 1'b0);
        cfg(3, 32'h4000, 15);
        push(3, 16'h0033, 32'h2, 1'b0, 1'b0);
        cfg(2, 32'h3000, 6);
        push(2, 16'h0044, 32'h3, 1'b1, 1'b0);
    endtask

    task automatic t_reconfig();
        cfg(0, 32'h1000, 7);                      // R5: back to slot 0, phase 1
        push(0, 16'h0055, 32'hBEEF, 1'b0, 1'b0);
    endtask

    task automatic t_independent();
        push(1, 16'h0066, 32'hCAFE, 1'b1, 1'b0);   // R11: q1 resumes at slot 1
        chk("R11", "q1 slot", 32'(m_idx[1]), 32'd2);
    endtask

    task automatic t_trigger();
        @(negedge clk); irq_en = 4'b0010;
        set_trig(1, 12'd2);                         // phase 0, slot 2: must not fire
        push(1, 16'h0077, 32'h7, 1'b0, 1'b0);
        chk("R7", "phase mismatch silent", irq_status, 4'b0000);
        set_trig(1, 12'd35);                        // phase 1 at bit 5, slot 3
        push(1, 16'h0088, 32'h8, 1'b0, 1'b0);
        chk("R7", "match sets status", irq_status, 4'b0010);
        chk("R8", "irq raised", irq, 1'b1);
        @(negedge clk); irq_en = 4'b0000; #1;
        chk("R8", "irq masked", irq, 1'b0);
        chk("R8", "status kept", irq_status, 4'b0010);
        @(negedge clk);
        irq_clr_we = 1'b1; irq_clr_mask = 4'b0010;
        @(negedge clk);
        irq_clr_we = 1'b0;
        chk("R9", "cleared", irq_status, 4'b0000);
    endtask

    task automatic t_set_vs_clear();
        @(negedge clk); irq_en = 4'b0010;
        set_trig(1, 12'd36);
        push(1, 16'h0099, 32'h9, 1'b0, 1'b1);
        chk("R9", "set beats clear", irq_status, 4'b0010);
        @(negedge clk);
        irq_clr_we = 1'b1; irq_clr_mask = 4'b1111;
        @(negedge clk);
        irq_clr_we = 1'b0;
        chk("R9", "clear all", irq_status, 4'b0000);
        irq_en = 4'b0000;
        set_trig(1, 12'd37);
        push(1, 16'h00AA, 32'hA, 1'b0, 1'b0);
        chk("R7", "match ignored when disabled", irq_status, 4'b0000);
        chk("R8", "irq low", irq, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_we = 0; cfg_qid = 0; cfg_base = 0; cfg_size_code = 0;
        trig_we = 0; trig_qid = 0; trig_pos = 0;
        cmp_valid = 0; cmp_qid = 0; cmp_rid = 0; cmp_status = 0; cmp_err = 0;
        irq_en = 0; irq_clr_we = 0; irq_clr_mask = 0;
        for (int q = 0; q < NQ; q++) begin
            m_base[q] = 0; m_code[q] = 0; m_idx[q] = 0; m_gen[q] = 1'b1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wrap();
        t_align();
        t_disabled();
        t_reconfig();
        t_independent();
        t_trigger();
        t_set_vs_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule